// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate with Rounding and Saturation

This block is the arithmetic heart of a signal-processing datapath. Each cycle it can take two signed fractional operands, form their exact double-width product, and add that product to, or subtract it from, an accumulator. It can also clear the accumulator or replace its contents with the product. The accumulator carries extra guard bits above the product's integer bits. A long run of sums can therefore leave the output range for a while and come back without losing any bits.

When the surrounding core wants to write a result back to memory, it pulses a store strobe and picks a rounding mode. The block narrows the accumulator to an operand-width word and applies truncation, round-half-up or round-half-to-even. It then checks the rounded value against the output range and clamps it to the largest or smallest word if it does not fit. A sticky overflow flag records that a clamp took place.

Top module: `fxp_mac_rnd`

## Requirements
- R1: After a synchronous active-low reset, the accumulator, `result_o` and `ovf_o` are all zero.
- R2: With `op_en` high and `op` = 2'b01, the accumulator gains `a_i*b_i` (signed product) at the next clock edge. A new operation can be issued every cycle. With `op_en` low the accumulator holds, whatever the operands are.
- R3: With `op_en` high and `op` = 2'b10, `a_i*b_i` is subtracted from the accumulator at the next clock edge.
- R4: `op` = 2'b00 sets the accumulator to zero. `op` = 2'b11 sets it to `a_i*b_i`. Both clear `ovf_o`, unless a store in the same cycle clamps.
- R5: Operands are Q1.23 fractions. The stored word is accumulator bits [46:23], and bits [22:0] are discarded. Rounding mode 2'b00 truncates, which gives the floor. Mode 2'b11 behaves the same way.
- R6: Rounding mode 2'b01 adds one to the kept word when the discarded part is one half or more.
- R7: Rounding mode 2'b10 rounds below one half down and above one half up. At exactly one half it rounds so that the kept LSB becomes zero.
- R8: A stored value is clamped to 24'h7FFFFF or 24'h800000 when it does not fit in 24 signed bits. Accumulator bits [55:46] must all be equal for the value to fit. The 8 guard bits keep intermediate sums exact, so a sum that left the range and came back stores unclamped.
- R9: The range check is made after rounding. A rounding increment that carries past the largest word clamps and raises the flag.
- R10: `ovf_o` is set by any store that clamps. It stays set until a clear or load operation.
- R11: `result_o` and the flag update on the edge at which `store` is sampled, and hold at all other times. A store reads the accumulator as it was before any operation issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Issue the operation in `op` this cycle |
| op | input | 2 | 00 clear, 01 accumulate, 10 subtract, 11 load product |
| a_i | input | 24 | First operand, signed Q1.23 |
| b_i | input | 24 | Second operand, signed Q1.23 |
| rnd_mode | input | 2 | 00 truncate, 01 half up, 10 half to even, 11 truncate |
| store | input | 1 | Capture the rounded, saturated accumulator |
| result_o | output | 24 | Last stored word, signed Q1.23 |
| ovf_o | output | 1 | Sticky flag: a stored word was clamped |

## Verification
Accumulation is driven with mixed-sign operand pairs across load, accumulate and subtract, so that a wrong sign or a swapped operation shows up in the stored word. Rounding uses products whose discarded fraction is a quarter, exactly a half with an even kept LSB, exactly a half with an odd kept LSB, and three quarters, for both positive and negative values. Only this set separates truncation, half-up and half-to-even from one another. Saturation is driven at the exact negative limit, just beyond each limit, after a guard-bit excursion that returns to range, and at a value that only overflows once rounded. Together these show where the range check sits and how long the flag stays set.

// File: rtl/fxp_mac_pkg.sv
// Shared encodings for the fixed-point multiply-accumulate block.
// Assumes a 2-bit operation field and a 2-bit rounding field.
package fxp_mac_pkg;

    typedef enum logic [1:0] {
        OP_CLR  = 2'b00,
        OP_MAC  = 2'b01,
        OP_MSU  = 2'b10,
        OP_LOAD = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC = 2'b00,
        RND_NEAR  = 2'b01,
        RND_CONV  = 2'b10,
        RND_RSVD  = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/fxp_mac_mult.sv
// Signed operand multiplier: produces the exact double-width product.
// Assumes both operands are two's complement of equal width.
module fxp_mac_mult #(
    parameter int OP_W = 24
) (
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic [2*OP_W-1:0] prod_o
);
    localparam int PROD_W = 2 * OP_W;

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;

    // Sign-extend to product width so the modulo product equals the exact one.
    always_comb begin
        a_ext  = {{OP_W{a_i[OP_W-1]}}, a_i};
        b_ext  = {{OP_W{b_i[OP_W-1]}}, b_i};
        prod_o = a_ext * b_ext;
    end
endmodule

// File: rtl/fxp_mac_acc.sv
// Guard-bit accumulator: clear, accumulate, subtract or load the product.
// Assumes the product is narrower than the accumulator by the guard width.
module fxp_mac_acc
    import fxp_mac_pkg::*;
#(
    parameter int PROD_W  = 48,
    parameter int GUARD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_en,
    input  logic [1:0]                op,
    input  logic [PROD_W-1:0]         prod_i,
    output logic [PROD_W+GUARD_W-1:0] acc_o
);
    localparam int ACC_W = PROD_W + GUARD_W;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;

    // Sign-extend the product into the guard bits.
    always_comb prod_ext = {{GUARD_W{prod_i[PROD_W-1]}}, prod_i};

    // Apply the issued operation; hold when nothing is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (op_en) begin
            case (mac_op_e'(op))
                OP_CLR:  acc_q <= '0;
                OP_MAC:  acc_q <= acc_q + prod_ext;
                OP_MSU:  acc_q <= acc_q - prod_ext;
                default: acc_q <= prod_ext;
            endcase
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/fxp_mac_round_sat.sv
// Narrows the accumulator to an operand-width word: rounds, then saturates.
// Assumes the output word sits just below the guard bits and the product's
// extra integer bit, so its LSB is OP_W-1 above accumulator bit 0.
module fxp_mac_round_sat
    import fxp_mac_pkg::*;
#(
    parameter int OP_W    = 24,
    parameter int GUARD_W = 8
) (
    input  logic [2*OP_W+GUARD_W-1:0] acc_i,
    input  logic [1:0]                mode_i,
    output logic [OP_W-1:0]           word_o,
    output logic                      sat_o
);
    localparam int ACC_W = 2 * OP_W + GUARD_W;
    localparam int SGN   = ACC_W - GUARD_W - 2;   // sign of output word
    localparam int LSB   = SGN - OP_W + 1;        // kept LSB
    localparam int HI_W  = ACC_W - LSB + 1;       // kept part plus carry bit
    localparam int TOP_W = ACC_W - SGN + 1;       // bits that must agree

    logic            half_bit;
    logic            below_half;
    logic            inc;
    logic [HI_W-1:0] hi_ext;
    logic [HI_W-1:0] hi_rnd;
    logic [TOP_W-1:0] top_bits;

    // Split the discarded fraction into its half bit and the bits below it.
    always_comb begin
        half_bit   = acc_i[LSB-1];
        below_half = |acc_i[LSB-2:0];
    end

    // Choose the rounding increment for the selected mode.
    always_comb begin
        case (rnd_mode_e'(mode_i))
            RND_NEAR: inc = half_bit;
            RND_CONV: inc = half_bit & (below_half | acc_i[LSB]);
            default:  inc = 1'b0;
        endcase
    end

    // Add the increment to the kept part with one extra sign bit for carry.
    always_comb begin
        hi_ext = {acc_i[ACC_W-1], acc_i[ACC_W-1:LSB]};
        hi_rnd = hi_ext + {{(HI_W-1){1'b0}}, inc};
    end

    // Range check after rounding, then clamp toward the sign.
    always_comb begin
        top_bits = hi_rnd[HI_W-1:SGN-LSB];
        sat_o    = !((&top_bits) || !(|top_bits));
        if (sat_o)
            word_o = hi_rnd[HI_W-1] ? {1'b1, {(OP_W-1){1'b0}}}
                                    : {1'b0, {(OP_W-1){1'b1}}};
        else
            word_o = hi_rnd[OP_W-1:0];
    end
endmodule

// File: rtl/fxp_mac_rnd.sv
// Fixed-point multiply-accumulate with guard bits, store-time rounding and
// saturation. One operation per cycle; a store reads the accumulator value
// from before any operation issued in the same cycle.
module fxp_mac_rnd
    import fxp_mac_pkg::*;
#(
    parameter int OP_W    = 24,
    parameter int GUARD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_en,
    input  logic [1:0]      op,
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    input  logic [1:0]      rnd_mode,
    input  logic            store,
    output logic [OP_W-1:0] result_o,
    output logic            ovf_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc_q;
    logic [OP_W-1:0]   word;
    logic              sat;
    logic              clr_hit;
    logic [OP_W-1:0]   result_q;
    logic              ovf_q;

    fxp_mac_mult #(.OP_W(OP_W)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    fxp_mac_acc #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_en  (op_en),
        .op     (op),
        .prod_i (prod),
        .acc_o  (acc_q)
    );

    fxp_mac_round_sat #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_rs (
        .acc_i  (acc_q),
        .mode_i (rnd_mode),
        .word_o (word),
        .sat_o  (sat)
    );

    // Detect operations that empty the accumulator and so reset the flag.
    always_comb clr_hit = op_en && ((mac_op_e'(op) == OP_CLR) || (mac_op_e'(op) == OP_LOAD));

    // Capture the stored word on a store strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (store)
            result_q <= word;
    end

    // Sticky clamp flag: cleared by clear/load, set by a clamping store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else
            ovf_q <= (ovf_q && !clr_hit) || (store && sat);
    end

    assign result_o = result_q;
    assign ovf_o    = ovf_q;
endmodule

// File: rtl/fxp_mac_rnd_chk.sv
// Property checker for fxp_mac_rnd, attached through bind.
module fxp_mac_rnd_chk #(
    parameter int OP_W  = 24,
    parameter int ACC_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_en,
    input logic [1:0]       op,
    input logic             store,
    input logic [OP_W-1:0]  result_o,
    input logic             ovf_o,
    input logic [ACC_W-1:0] acc_q
);
    logic clr_or_load;
    always_comb clr_or_load = op_en && ((op == 2'b00) || (op == 2'b11));

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(acc_q)); // R2
    AST_ACC_ZERO_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == 2'b00) |=> (acc_q == '0)); // R4
    AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_or_load && !store) |=> !ovf_o); // R4
    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (result_o == {1'b0, {(OP_W-1){1'b1}}} ||
                          result_o == {1'b1, {(OP_W-1){1'b0}}})); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_or_load) |=> ovf_o); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> $stable(result_o)); // R11
endmodule

bind fxp_mac_rnd fxp_mac_rnd_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .op       (op),
    .store    (store),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .acc_q    (acc_q)
);

// File: tb/tb_fxp_mac_rnd.sv
`timescale 1ns/1ps
module tb_fxp_mac_rnd;
    localparam int W = 24;
    localparam logic [W-1:0] MAXW = 24'h7FFFFF;
    localparam logic [W-1:0] MINW = 24'h800000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_en = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         store = 1'b0;
    logic [W-1:0] result_o;
    logic         ovf_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    longint       acc_m = 0;
    bit           ovf_m = 0;
    logic [W-1:0] res_m = '0;

    always #2.5 clk = ~clk;

    fxp_mac_rnd dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .a_i(a_i), .b_i(b_i),
        .rnd_mode(rnd_mode), .store(store), .result_o(result_o), .ovf_o(ovf_o)
    );

    function automatic longint sx(input logic [W-1:0] v);
        longint r;
        r = $signed(v);
        return r;
    endfunction

    // Expected store from the requirements: floor split, mode increment, clamp.
    function automatic void model_store(input longint acc, input int mode,
                                        output logic [W-1:0] res, output bit sat);
        longint q, rem, r;
        bit inc;
        q   = acc >>> 23;
        rem = acc - (q <<< 23);
        if (mode == 1)      inc = (rem >= 64'sd4194304);
        else if (mode == 2) inc = (rem > 64'sd4194304) || (rem == 64'sd4194304 && q[0]);
        else                inc = 0;
        r = q + longint'(inc);
        sat = 0;
        if (r > 64'sd8388607)       begin res = MAXW; sat = 1; end
        else if (r < -64'sd8388608) begin res = MINW; sat = 1; end
        else                        res = r[W-1:0];
    endfunction

    // One clock of stimulus; updates the reference model, then idles inputs.
    task automatic cycle(input bit en, input logic [1:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b, input bit st, input logic [1:0] m);
        longint p;
        logic [W-1:0] r;
        bit s;
        @(negedge clk);
        op_en = en; op = o; a_i = a; b_i = b; store = st; rnd_mode = m;
        p = sx(a) * sx(b);
        if (st) begin
            model_store(acc_m, int'(m), r, s);
            res_m = r;
        end else s = 0;
        ovf_m = (ovf_m && !(en && (o == 2'b00 || o == 2'b11))) || (st && s);
        if (en) begin
            case (o)
                2'b00: acc_m = 0;
                2'b01: acc_m = acc_m + p;
                2'b10: acc_m = acc_m - p;
                default: acc_m = p;
            endcase
        end
        @(negedge clk);
        op_en = 0; store = 0;
        a_i = $urandom; b_i = $urandom; op = 2'($urandom);
    endtask

    task automatic issue(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        cycle(1, o, a, b, 0, 2'b00);
    endtask

    task automatic check(input string tag, input logic [W-1:0] exp_r, input bit exp_o);
        n_checks++;
        if (result_o !== exp_r || ovf_o !== exp_o) begin
            n_errors++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     tag, result_o, ovf_o, exp_r, exp_o);
        end
    endtask

    task automatic store_check(input string tag, input logic [1:0] m);
        cycle(0, 2'b00, '0, '0, 1, m);
        check(tag, res_m, ovf_m);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset outputs", '0, 0);
        store_check("R1 reset accumulator zero", 2'b01);
    endtask

    task automatic t_mac;
        issue(2'b11, 24'h400000, 24'h400000);
        issue(2'b01, 24'h200000, 24'h400000);
        store_check("R2 accumulate positive", 2'b00);
        check("R2 0.375 value", 24'h300000, 0);
        issue(2'b01, 24'hC00000, 24'h200000);
        issue(2'b01, 24'hE00000, 24'hC00000);
        store_check("R2 accumulate mixed signs", 2'b00);
    endtask

    task automatic t_msu;
        issue(2'b00, '0, '0);
        issue(2'b10, 24'h400000, 24'h600000);
        issue(2'b01, 24'h400000, 24'h200000);
        store_check("R3 subtract", 2'b00);
        check("R3 -0.25 value", 24'hE00000, 0);
    endtask

    task automatic t_hold;
        issue(2'b11, 24'h123456, 24'h2468AC);
        store_check("R2 reference before idle", 2'b00);
        for (int i = 0; i < 6; i++) cycle(0, 2'($urandom), $urandom, $urandom, 0, 2'b00);
        check("R11 result held without store", res_m, ovf_m);
        store_check("R2 accumulator held when op_en low", 2'b00);
    endtask

    task automatic t_clear;
        issue(2'b11, 24'h300000, 24'h500000);
        issue(2'b00, 24'h7FFFFF, 24'h7FFFFF);
        store_check("R4 clear gives zero", 2'b01);
        check("R4 zero value", '0, 0);
        issue(2'b01, 24'h100000, 24'h100000);
        issue(2'b11, 24'hA00000, 24'h400000);
        store_check("R4 load replaces accumulator", 2'b00);
    endtask

    task automatic t_round;
        logic [W-1:0] av[5] = '{24'h000001, 24'h000003, 24'h000005, 24'h000007, 24'hFFFFFD};
        logic [W-1:0] bv[5] = '{24'h400000, 24'h400000, 24'h200000, 24'h200000, 24'h400000};
        logic [W-1:0] et[5] = '{24'h000000, 24'h000001, 24'h000001, 24'h000001, 24'hFFFFFE};
        logic [W-1:0] en[5] = '{24'h000001, 24'h000002, 24'h000001, 24'h000002, 24'hFFFFFF};
        logic [W-1:0] ec[5] = '{24'h000000, 24'h000002, 24'h000001, 24'h000002, 24'hFFFFFE};
        for (int i = 0; i < 5; i++) begin
            issue(2'b11, av[i], bv[i]);
            cycle(0, 2'b00, '0, '0, 1, 2'b00); check($sformatf("R5 truncate case %0d", i), et[i], 0);
            cycle(0, 2'b00, '0, '0, 1, 2'b11); check($sformatf("R5 mode 3 truncates case %0d", i), et[i], 0);
            cycle(0, 2'b00, '0, '0, 1, 2'b01); check($sformatf("R6 half up case %0d", i), en[i], 0);
            cycle(0, 2'b00, '0, '0, 1, 2'b10); check($sformatf("R7 half even case %0d", i), ec[i], 0);
        end
    endtask

    task automatic t_sat;
        issue(2'b11, 24'h800000, 24'h800000);
        store_check("R8 +1.0 clamps high", 2'b00);
        check("R8 high clamp value", MAXW, 1);
        issue(2'b00, '0, '0);
        issue(2'b10, 24'h800000, 24'h800000);
        store_check("R8 exact -1.0 not clamped", 2'b01);
        check("R8 min value no flag", MINW, 0);
        issue(2'b10, 24'h000001, 24'h400000);
        store_check("R8 below -1.0 clamps low", 2'b00);
        check("R8 low clamp value", MINW, 1);
    endtask

    task automatic t_guard;
        issue(2'b11, 24'h800000, 24'h800000);
        for (int i = 0; i < 3; i++) issue(2'b01, 24'h800000, 24'h800000);
        store_check("R8 guard excursion clamps", 2'b10);
        for (int i = 0; i < 4; i++) issue(2'b10, 24'h800000, 24'h800000);
        issue(2'b01, 24'h400000, 24'h400000);
        store_check("R8 guard bits recover exact sum", 2'b00);
        check("R10 flag still set after in-range store", 24'h200000, 1);
        issue(2'b00, '0, '0);
        check("R10 flag cleared by clear", 24'h200000, 0);
    endtask

    task automatic t_round_ovf;
        issue(2'b11, 24'h800000, 24'h800000);
        issue(2'b10, 24'h000001, 24'h400000);
        store_check("R9 truncation stays in range", 2'b00);
        check("R9 truncate no flag", MAXW, 0);
        store_check("R9 half up overflows after rounding", 2'b01);
        check("R9 half up raises flag", MAXW, 1);
        issue(2'b11, 24'h800000, 24'h800000);
        issue(2'b10, 24'h000001, 24'h400000);
        store_check("R9 half even overflows after rounding", 2'b10);
    endtask

    task automatic t_same_cycle;
        issue(2'b11, 24'h200000, 24'h400000);
        cycle(1, 2'b01, 24'h400000, 24'h400000, 1, 2'b00);
        check("R11 store sees pre-operation value", 24'h100000, 0);
        store_check("R11 following store sees new value", 2'b00);
        check("R11 new value", 24'h300000, 0);
        issue(2'b11, 24'h800000, 24'h800000);
        cycle(1, 2'b00, '0, '0, 1, 2'b00);
        check("R4 clamping store with clear keeps flag", MAXW, 1);
    endtask

    initial begin
        t_reset();
        t_mac();
        t_msu();
        t_hold();
        t_clear();
        t_round();
        t_sat();
        t_guard();
        t_round_ovf();
        t_same_cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule